// File: doc/BRIEF.md
# External Clock Activity Monitor

This block watches a fast external clock from a system clock domain and reports two conditions. The first is that the external clock has stopped. The second is that the external clock has been running long enough to use. A slower reference clock defines check windows. Each interval during which the reference is low must contain at least one falling edge of the external clock. The reference must run below half the external frequency, so a healthy external clock always meets this.

Both clocks are sampled by the system clock through two-flop synchronizers, and edges are found by comparing consecutive synchronized samples. The system clock must be at least four times faster than the external clock. A missed-window counter raises the inactivity flag after two consecutive empty windows. A settle counter counts external falling edges after the generator enable goes high and then raises the ready flag. The settle length is 4096 edges in crystal mode and 16 edges otherwise. The ready flag is forced low while the enable is low or the inactivity flag is high.

Top module: `xclk_watch`

## Requirements
- R1: A synchronous active-high reset drives both `ext_dead_o` and `ext_ready_o` low and clears every counter.
- R2: An external falling edge seen while the synchronized reference is low resets the missed-window count. A single empty window followed by a good one does not raise `ext_dead_o`.
- R3: `ext_dead_o` rises at the end of the second consecutive reference-low window that holds no external falling edge. A window ends on a synchronized rising edge of the reference.
- R4: Once set, `ext_dead_o` falls on the next external falling edge that arrives while the synchronized reference is low.
- R5: With `xtal_mode_i` = 0 and `gen_en_i` = 1, `ext_ready_o` rises on the 16th external falling edge counted since the count began.
- R6: With `xtal_mode_i` = 1, `ext_ready_o` rises on the 4096th counted external falling edge.
- R7: While `gen_en_i` is low, `ext_ready_o` is low one cycle later and the settle count restarts from zero. Counting resumes only when `gen_en_i` is high again.
- R8: While `ext_dead_o` is high, `ext_ready_o` is low one cycle later and the settle count is held at zero. A fresh full count follows the clearing of `ext_dead_o`.
- R9: A level change on `ext_clk_i` or `ref_clk_i` applied before clock edge k affects the registered outputs no earlier than after edge k+2. Edge k captures the new level, edge k+1 exposes the edge, and edge k+2 registers the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the external clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External clock being monitored (asynchronous) |
| ref_clk_i | input | 1 | Slower reference clock that defines check windows (asynchronous) |
| gen_en_i | input | 1 | External generator enable; a rise starts the settle count |
| xtal_mode_i | input | 1 | 1 selects the long (4096) settle count, 0 the short (16) |
| ext_dead_o | output | 1 | External clock inactivity flag |
| ext_ready_o | output | 1 | External clock settled and usable |

## Verification
One corner case is a gap in the external clock that empties exactly one reference-low window. A design that flags on a single miss, or that fails to clear its count on a good edge, would raise the inactivity flag here. A long stop is checked against the ready flag as well, because a design that forgets to clear ready on inactivity, or that resumes a partial count afterwards, would report ready too early. The enable is pulsed low in the middle of operation, and the long crystal count is checked just short of and just past 4096 edges. This catches an off-by-one terminal count or a wrongly selected count. A behavioural model compares both flags on every cycle and pins the three-edge input-to-output latency.

// File: rtl/xclk_watch_pkg.sv
package xclk_watch_pkg;

    localparam int LONG_SETTLE  = 4096;
    localparam int SHORT_SETTLE = 16;
    localparam int MISS_LIMIT   = 2;
    localparam int SYNC_DEPTH   = 2;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_info_t;

    function automatic int settle_len(input logic long_mode, input int long_n, input int short_n);
        return long_mode ? long_n : short_n;
    endfunction

endpackage

// File: rtl/xw_sync_edge.sv
module xw_sync_edge
    import xclk_watch_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output edge_info_t edg
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    always_comb begin
        edg.lvl  = sh_q[STAGES-1];
        edg.rise = sh_q[STAGES-1] & ~sh_q[STAGES];
        edg.fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/xw_window_check.sv
module xw_window_check
    import xclk_watch_pkg::*;
#(
    parameter int LIMIT  = MISS_LIMIT,
    localparam int MISS_W = $clog2(LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_fall,
    input  logic              ref_lvl,
    input  logic              ref_rise,
    output logic              dead_o,
    output logic [MISS_W-1:0] miss_o
);
    logic              seen_q;
    logic [MISS_W-1:0] miss_q;
    logic              dead_q;
    logic              hit;

    assign hit = ext_fall & ~ref_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            miss_q <= '0;
            dead_q <= 1'b0;
        end else if (hit) begin
            seen_q <= 1'b1;
            miss_q <= '0;
            dead_q <= 1'b0;
        end else if (ref_rise) begin
            seen_q <= 1'b0;
            if (!seen_q) begin
                if (miss_q != MISS_W'(LIMIT)) miss_q <= miss_q + 1'b1;
                if (miss_q >= MISS_W'(LIMIT - 1)) dead_q <= 1'b1;
            end
        end
    end

    assign dead_o = dead_q;
    assign miss_o = miss_q;
endmodule

// File: rtl/xw_settle_count.sv
module xw_settle_count
    import xclk_watch_pkg::*;
#(
    parameter int LONG_N  = LONG_SETTLE,
    parameter int SHORT_N = SHORT_SETTLE,
    localparam int CNT_W  = $clog2(LONG_N + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_fall,
    input  logic enable,
    input  logic long_mode,
    input  logic dead,
    output logic ready_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             ready_q;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(settle_len(long_mode, LONG_N, SHORT_N) - 1);

    always_ff @(posedge clk) begin
        if (rst || !enable || dead) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (ext_fall && !ready_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= last) ready_q <= 1'b1;
        end
    end

    assign ready_o = ready_q;
endmodule

// File: rtl/xclk_watch.sv
module xclk_watch
    import xclk_watch_pkg::*;
#(
    parameter int LONG_N  = LONG_SETTLE,
    parameter int SHORT_N = SHORT_SETTLE,
    parameter int LIMIT   = MISS_LIMIT,
    parameter int STAGES  = SYNC_DEPTH,
    localparam int MISS_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk_i,
    input  logic ref_clk_i,
    input  logic gen_en_i,
    input  logic xtal_mode_i,
    output logic ext_dead_o,
    output logic ext_ready_o
);
    localparam int EXT = 0;
    localparam int REF = 1;

    logic [1:0]        raw;
    edge_info_t        chan [2];
    logic              dead;
    logic [MISS_W-1:0] miss_cnt;

    assign raw = {ref_clk_i, ext_clk_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        xw_sync_edge #(.STAGES(STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .edg (chan[g])
        );
    end

    xw_window_check #(.LIMIT(LIMIT)) u_win (
        .clk      (clk),
        .rst      (rst),
        .ext_fall (chan[EXT].fall),
        .ref_lvl  (chan[REF].lvl),
        .ref_rise (chan[REF].rise),
        .dead_o   (dead),
        .miss_o   (miss_cnt)
    );

    xw_settle_count #(.LONG_N(LONG_N), .SHORT_N(SHORT_N)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .ext_fall  (chan[EXT].fall),
        .enable    (gen_en_i),
        .long_mode (xtal_mode_i),
        .dead      (dead),
        .ready_o   (ext_ready_o)
    );

    assign ext_dead_o = dead;
endmodule

// File: rtl/xclk_watch_chk.sv
module xclk_watch_chk #(
    parameter int LIMIT  = 2,
    parameter int MISS_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              gen_en,
    input logic              dead,
    input logic              ready,
    input logic              ext_fall,
    input logic              ref_lvl,
    input logic              ref_rise,
    input logic [MISS_W-1:0] miss
);
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> (!dead && !ready));

    p_miss_saturates_r2: assert property (@(posedge clk) disable iff (rst)
        miss <= MISS_W'(LIMIT));

    p_dead_on_window_end_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dead) |-> $past(ref_rise));

    p_dead_clears_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(dead) |-> $past(ext_fall && !ref_lvl));

    p_ready_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(ext_fall));

    p_ready_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !ready);

    p_ready_blocked_by_dead_r8: assert property (@(posedge clk) disable iff (rst)
        dead |=> !ready);
endmodule

bind xclk_watch xclk_watch_chk #(.LIMIT(LIMIT), .MISS_W(MISS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gen_en   (gen_en_i),
    .dead     (ext_dead_o),
    .ready    (ext_ready_o),
    .ext_fall (chan[0].fall),
    .ref_lvl  (chan[1].lvl),
    .ref_rise (chan[1].rise),
    .miss     (miss_cnt)
);

// File: tb/sim_xclk_watch.sv
module sim_xclk_watch;
    localparam int CLK_PERIOD = 10;
    localparam int EXT_HALF   = 3;
    localparam int REF_HALF   = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic gen_en = 1'b0;
    logic xtal = 1'b0;
    logic ext_run = 1'b1;
    logic dead, ready;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    int rcnt = 0;

    xclk_watch u0 (
        .clk         (clk),
        .rst         (rst),
        .ext_clk_i   (ext_clk),
        .ref_clk_i   (ref_clk),
        .gen_en_i    (gen_en),
        .xtal_mode_i (xtal),
        .ext_dead_o  (dead),
        .ext_ready_o (ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // stimulus clocks, changed on the falling system edge
    always @(negedge clk) begin
        if (ext_run) begin
            if (ecnt == EXT_HALF - 1) begin ext_clk <= ~ext_clk; ecnt <= 0; end
            else ecnt <= ecnt + 1;
        end
        if (rcnt == REF_HALF - 1) begin ref_clk <= ~ref_clk; rcnt <= 0; end
        else rcnt <= rcnt + 1;
    end

    // behavioural reference model
    bit eq[$];
    bit rq[$];
    int m_miss = 0;
    int m_cnt = 0;
    bit m_seen = 0, m_dead = 0, m_ready = 0;

    always @(posedge clk) begin
        if (rst) begin
            eq = '{0, 0, 0};
            rq = '{0, 0, 0};
            m_miss = 0; m_cnt = 0; m_seen = 0; m_dead = 0; m_ready = 0;
        end else begin
            // an input edge becomes usable three samples later (R9)
            bit efall, rlow, rrise, was_dead;
            int target;
            efall = eq[2] && !eq[1];
            rlow  = !rq[1];
            rrise = !rq[2] && rq[1];
            was_dead = m_dead;
            if (efall && rlow) begin
                m_seen = 1; m_miss = 0; m_dead = 0;
            end else if (rrise) begin
                if (!m_seen) begin
                    if (m_miss < 2) m_miss++;
                    if (m_miss >= 2) m_dead = 1;
                end
                m_seen = 0;
            end
            target = xtal ? 4096 : 16;
            if (!gen_en || was_dead) begin
                m_cnt = 0; m_ready = 0;
            end else if (efall && !m_ready) begin
                m_cnt++;
                if (m_cnt >= target) m_ready = 1;
            end
            eq.push_front(ext_clk); void'(eq.pop_back());
            rq.push_front(ref_clk); void'(rq.pop_back());
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(dead == m_dead, "R2/R3/R4/R9 dead vs model", dead, m_dead);
            check(ready == m_ready, "R5/R6/R7/R8/R9 ready vs model", ready, m_ready);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(5);
        check(dead == 0, "R1 dead after reset", dead, 0);
        check(ready == 0, "R1 ready after reset", ready, 0);
        rst = 1'b0;

        // R5 short settle count
        gen_en = 1'b1;
        wait_cyc(40);
        check(ready == 0, "R5 ready before 16 edges", ready, 0);
        wait_cyc(120);
        check(ready == 1, "R5 ready after 16 edges", ready, 1);

        // R7 enable drop
        gen_en = 1'b0;
        wait_cyc(3);
        check(ready == 0, "R7 ready low with enable low", ready, 0);
        gen_en = 1'b1;
        wait_cyc(20);
        check(ready == 0, "R7 count restarted", ready, 0);
        wait_cyc(130);
        check(ready == 1, "R7 ready after recount", ready, 1);

        // R2 one empty window only
        ext_run = 1'b0;
        wait_cyc(26);
        ext_run = 1'b1;
        wait_cyc(100);
        check(dead == 0, "R2 single miss not flagged", dead, 0);

        // R3 / R8 long stop
        ext_run = 1'b0;
        wait_cyc(120);
        check(dead == 1, "R3 dead after two empty windows", dead, 1);
        check(ready == 0, "R8 ready cleared by dead", ready, 0);

        // R4 restart
        ext_run = 1'b1;
        wait_cyc(60);
        check(dead == 0, "R4 dead cleared by edge", dead, 0);
        check(ready == 0, "R8 fresh count needed", ready, 0);
        wait_cyc(200);
        check(ready == 1, "R8 ready after recount", ready, 1);

        // R6 long settle count
        gen_en = 1'b0;
        wait_cyc(2);
        xtal = 1'b1;
        gen_en = 1'b1;
        wait_cyc(24000);
        check(ready == 0, "R6 ready before 4096 edges", ready, 0);
        wait_cyc(1000);
        check(ready == 1, "R6 ready after 4096 edges", ready, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule